// File: doc/BRIEF.md
# Write-Completing Memory Select Guard

This block sits between the address decoder and a memory device and guards the memory's active-low chip select against corruption while the system supervisor holds reset. When the system is out of reset the select passes straight through with no added register stage. When the supervisor reset flag is seen asserted at a clock edge, the guard closes so that no new access can start. An access already in flight at that edge may finish. The select is kept low until the requester releases it or until a bounded completion window runs out, whichever comes first. A closed guard drives the output high and keeps it high until reset is released.

The behaviour is held in a three-state machine. `GATE_OPEN` passes the select through. `GATE_HOLD` lets a write that was caught by reset run to completion. `GATE_SHUT` forces the output high. The transitions are named as follows. *open→shut* occurs when reset is sampled with the select high. *open→hold* occurs when reset is sampled with the select low, and it starts the window timer. *hold→shut* occurs when the select is sampled high or the window expires. *hold→open* and *shut→open* occur when reset is sampled low. *shut→shut* applies while reset stays high. A state that is not one of these three goes to shut while reset is high. The window is a cycle count derived from the clock frequency and a time in nanoseconds. The defaults are 50 MHz and 15 000 ns, which gives 750 cycles.

Top module: `cs_write_guard`

## Requirements
- R1: After a clock edge that samples `sys_rst` low (1 = reset), `cs_out_n` equals `cs_in_n` combinationally until the next edge (chip select is active low, 0 = selected).
- R2: `cs_out_n` is low only when `cs_in_n` is low.
- R3: A clock edge that samples `sys_rst` high while the guard is open and `cs_in_n` is high closes the guard, and `cs_out_n` is 1 from that edge on.
- R4: A clock edge that samples `sys_rst` high while the guard is open and `cs_in_n` is low enters the hold state, in which `cs_out_n` keeps following `cs_in_n`. An edge in hold that samples `cs_in_n` high closes the guard.
- R5: The hold state lasts at most HOLD_CYC clock edges. If reset is first sampled at edge k and the select stays low, `cs_out_n` is 0 after edges k through k+HOLD_CYC-1 and 1 after edge k+HOLD_CYC (HOLD_CYC = 750 by default).
- R6: Once the guard is closed, `cs_out_n` stays 1 whatever `cs_in_n` does, including a return to 0, until an edge samples `sys_rst` low.
- R7: At power-up with `sys_rst` high, `cs_out_n` is 1 after the first clock edge, regardless of input activity.
- R8: When reset is released, the guard stays closed until the first clock edge that samples `sys_rst` low, and `cs_out_n` follows the input from that edge.
- R9: If an edge samples `sys_rst` low during the hold state, the guard returns to open without closing, and the select stays low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state machine and window timer |
| sys_rst | input | 1 | Supervisor reset flag, 1 = reset asserted |
| cs_in_n | input | 1 | Requested memory chip select, active low |
| cs_out_n | output | 1 | Guarded memory chip select, active low; 1 when closed |

## Verification
The pass-through path has no register. The expected output is therefore due in the same cycle as a change of `cs_in_n`, once the state set at the previous edge is taken into account. State changes caused by `sys_rst` or by a sampled select show up one edge later. The window closes exactly HOLD_CYC edges after the edge that first sees reset. Inputs are driven at the falling clock edge, and the output is checked 1 ns later against a bench model that is updated at each rising edge. Directed cases count edges explicitly around the window boundary, the release of reset and the return to open from hold.

// File: rtl/cs_guard_pkg.sv
package cs_guard_pkg;
    typedef enum logic [1:0] {
        GATE_SHUT = 2'b00,
        GATE_OPEN = 2'b01,
        GATE_HOLD = 2'b10
    } gate_state_t;
endpackage

// File: rtl/cs_hold_timer.sv
// Counts edges spent in the hold state; expired marks the last allowed edge.
module cs_hold_timer #(
    parameter int HOLD_CYC = 750
) (
    input  logic clk,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);
endmodule

// File: rtl/cs_gate_fsm.sv
// Open / hold / shut controller for the select guard.
module cs_gate_fsm
    import cs_guard_pkg::*;
(
    input  logic clk,
    input  logic sys_rst,
    input  logic cs_in_n,
    input  logic win_expired,
    output logic gate_on,
    output logic win_clear,
    output logic win_run
);
    gate_state_t state_q, state_d;

    // Next-state decision.
    always_comb begin
        state_d = GATE_SHUT;
        if (!sys_rst) begin
            state_d = GATE_OPEN;
        end else begin
            unique case (state_q)
                GATE_OPEN: state_d = cs_in_n ? GATE_SHUT : GATE_HOLD;
                GATE_HOLD: state_d = (cs_in_n || win_expired) ? GATE_SHUT : GATE_HOLD;
                GATE_SHUT: state_d = GATE_SHUT;
                default:   state_d = GATE_SHUT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        gate_on   = 1'b0;
        win_clear = 1'b1;
        win_run   = 1'b0;
        unique case (state_q)
            GATE_OPEN: gate_on = 1'b1;
            GATE_HOLD: begin
                gate_on   = 1'b1;
                win_clear = 1'b0;
                win_run   = 1'b1;
            end
            GATE_SHUT: gate_on = 1'b0;
            default:   gate_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/cs_write_guard.sv
module cs_write_guard #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int HOLD_NS = 15_000
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic cs_in_n,
    output logic cs_out_n
);
    localparam int RAW_CYC  = (CLK_HZ / 1000) * HOLD_NS / 1_000_000;
    localparam int HOLD_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

    logic gate_on;
    logic win_clear;
    logic win_run;
    logic win_expired;

    cs_gate_fsm u_fsm (
        .clk         (clk),
        .sys_rst     (sys_rst),
        .cs_in_n     (cs_in_n),
        .win_expired (win_expired),
        .gate_on     (gate_on),
        .win_clear   (win_clear),
        .win_run     (win_run)
    );

    cs_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk     (clk),
        .clear   (win_clear),
        .run     (win_run),
        .expired (win_expired)
    );

    // Combinational pass path: low only when requested and the gate is on.
    assign cs_out_n = cs_in_n | ~gate_on;
endmodule

// File: rtl/cs_write_guard_chk.sv
module cs_write_guard_chk #(
    parameter int HOLD_CYC = 750
) (
    input logic clk,
    input logic sys_rst,
    input logic cs_in_n,
    input logic cs_out_n
);
    bit armed = 1'b0;
    int rst_run = 0;

    always @(posedge clk) begin
        armed <= 1'b1;
        if (!sys_rst) rst_run <= 0;
        else if (rst_run <= HOLD_CYC) rst_run <= rst_run + 1;
    end

    // R2
    out_implies_req_chk: assert property (@(posedge clk) disable iff (!armed)
        !cs_out_n |-> !cs_in_n);

    // R1
    open_follow_chk: assert property (@(posedge clk) disable iff (!armed)
        !$past(sys_rst) |-> (cs_out_n == cs_in_n));

    // R6
    shut_sticky_chk: assert property (@(posedge clk) disable iff (!armed)
        ($past(sys_rst) && $past(cs_out_n)) |-> cs_out_n);

    // R5
    window_bound_chk: assert property (@(posedge clk) disable iff (!armed)
        (rst_run > HOLD_CYC) |-> cs_out_n);
endmodule

bind cs_write_guard cs_write_guard_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk      (clk),
    .sys_rst  (sys_rst),
    .cs_in_n  (cs_in_n),
    .cs_out_n (cs_out_n)
);

// File: tb/cs_write_guard_tb.sv
`timescale 1ns/1ps
module cs_write_guard_tb_top;
    localparam int HOLD = 750;
    localparam int SH = 0, OP = 1, HD = 2;

    logic clk = 1'b0;
    logic sys_rst = 1'b1;
    logic cs_in_n = 1'b0;
    logic cs_out_n;

    int n_run = 0;
    int n_fail = 0;
    int m_state = SH;
    int m_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cs_write_guard dut_i (
        .clk      (clk),
        .sys_rst  (sys_rst),
        .cs_in_n  (cs_in_n),
        .cs_out_n (cs_out_n)
    );

    // Reference model from the requirements, stepped at each rising edge.
    always @(posedge clk) begin
        if (!sys_rst) begin
            m_state <= OP;
            m_cnt   <= 0;
        end else begin
            case (m_state)
                OP: begin
                    m_state <= cs_in_n ? SH : HD;
                    m_cnt   <= 0;
                end
                HD: begin
                    if (cs_in_n || m_cnt == HOLD - 1) m_state <= SH;
                    else m_cnt <= m_cnt + 1;
                end
                default: m_state <= SH;
            endcase
        end
    end

    function automatic logic exp_out(int st, logic cs);
        return (st == SH) ? 1'b1 : cs;
    endfunction

    function automatic string tag_of(int st);
        if (st == OP) return "R1";
        if (st == HD) return "R4";
        return "R6";
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: cs_out_n=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, then compare with the model.
    task automatic cyc(logic rst, logic cs);
        @(negedge clk);
        sys_rst = rst;
        cs_in_n = cs;
        #1;
        check(tag_of(m_state), cs_out_n, exp_out(m_state, cs));
        if (!cs_out_n) check("R2", cs_in_n, 1'b0);
    endtask

    task automatic run_all;
        // R7: power-up with reset and input activity
        cyc(1'b1, 1'b0);
        check("R7", cs_out_n, 1'b1);
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, i[0]);
            check("R7", cs_out_n, 1'b1);
        end
        // R8: released but not yet sampled -> still shut
        cyc(1'b0, 1'b0);
        check("R8", cs_out_n, 1'b1);
        cyc(1'b0, 1'b0);
        check("R8", cs_out_n, 1'b0);
        cyc(1'b0, 1'b1);
        check("R1", cs_out_n, 1'b1);
        // R3: reset with select high, then select low again
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b0);
        check("R3", cs_out_n, 1'b1);
        cyc(1'b1, 1'b0);
        check("R6", cs_out_n, 1'b1);
        // R5: window runs out with select held low
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);            // edge k follows this
        for (int j = 0; j < HOLD; j++) begin
            cyc(1'b1, 1'b0);        // checked after edge k+j
            check("R5", cs_out_n, 1'b0);
        end
        cyc(1'b1, 1'b0);            // after edge k+HOLD
        check("R5", cs_out_n, 1'b1);
        cyc(1'b1, 1'b0);
        check("R6", cs_out_n, 1'b1);
        // R4: select released early closes the guard
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        for (int j = 0; j < 10; j++) cyc(1'b1, 1'b0);
        check("R4", cs_out_n, 1'b0);
        cyc(1'b1, 1'b1);
        check("R4", cs_out_n, 1'b1);
        cyc(1'b1, 1'b0);
        check("R6", cs_out_n, 1'b1);
        // R9: reset released during hold
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        for (int j = 0; j < 20; j++) cyc(1'b1, 1'b0);
        for (int j = 0; j < HOLD + 5; j++) begin
            cyc(1'b0, 1'b0);
            check("R9", cs_out_n, 1'b0);
        end
        // Random mix
        for (int i = 0; i < 6000; i++) begin
            logic r;
            logic c;
            r = ($urandom % 100) < ((sys_rst) ? 97 : 3) ? 1'b1 : 1'b0;
            c = ($urandom % 4) != 0 ? cs_in_n : ~cs_in_n;
            cyc(r, c);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        fork
            begin
                run_all();
                done = 1'b1;
            end
            begin
                #(20 * 200_000);
            end
        join_any
        disable fork;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule